// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

The engine takes received Ethernet frames from a byte stream and files each into a ring of receive descriptors. The descriptors live in a small memory inside the block. A descriptor holds a 16-bit status word, a 16-bit length and a 32-bit buffer base address. Host software owns a descriptor while its empty bit is clear. It hands the descriptor to the engine by setting that bit. The engine consumes empty descriptors in ring order. For each one it writes the frame bytes out on a byte-write port, starting at the descriptor's buffer base. It then records the length and the error flags, clears the empty bit and moves on. It returns to descriptor 0 after any descriptor whose wrap bit is set.

Polling is armed by a doorbell: a write of one specific value to a control register. When the engine meets a descriptor the host has not yet returned, it disarms. From then on it discards arriving frames until the next doorbell. Every discarded frame is counted in a saturating overflow counter that the host can read.

The host sees one word-addressed register port. Address bit 0 selects the field and the bits above it select the descriptor. The top address bit selects the control space instead of the descriptor store.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset the engine is disarmed, the overflow counter reads 0 and every descriptor word reads 0.
- R2: A host write of exactly 32'h0100_0000 to control offset 0 (address with top bit 1, bit 0 = 0) arms polling. A write of any other value there leaves the engine disarmed, and the next frame is dropped and counted.
- R3: An armed engine accepts a frame only if the current descriptor has its empty bit (status bit 15) set. Byte k of an accepted frame appears on the byte-write port at address base+k, with the data unchanged and in order.
- R4: At the last byte of an accepted frame, the engine writes back descriptor word 0 = {status, length}. The length is the byte count including the 4-byte FCS. Status bit 15 is cleared, bits 5:0 are replaced by the frame's error flags, and all other status bits (wrap bit 13 included) keep the value the host wrote.
- R5: After closing a descriptor, the engine moves to the next index. It goes to index 0 instead when the closed descriptor had its wrap bit (status bit 13) set, or when it was the last entry of the ring.
- R6: A frame that starts when the current descriptor is not empty disarms the engine. The frame is dropped, the overflow counter goes up by 1, and the descriptor and index are left unchanged. Later frames are dropped the same way until a doorbell arrives.
- R7: A frame that starts while the engine is disarmed is dropped without any byte write, and the overflow counter goes up by 1. The counter saturates at its all-ones value.
- R8: An error flag on the last byte sets status bit 0 of the descriptor. The descriptor is still consumed and the index still advances.
- R9: A frame longer than MAX_FRAME bytes sets status bit 5. Bytes at offsets of BUF_BYTES or more are not written out, and the reported length saturates at BUF_BYTES.
- R10: A host read returns its data in the cycle after host_re. Field 0 of a descriptor reads {status, length}, field 1 reads the buffer base, and control offset 1 reads the overflow counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | clog2(RING_DEPTH)+2 | Word address: top bit selects control space, bit 0 selects the field or control offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after host_re |
| rx_valid | input | 1 | A frame byte is present |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | This byte ends the frame |
| rx_err | input | 1 | Frame error flag, sampled with rx_last |
| mem_we | output | 1 | Byte-write strobe toward buffer memory |
| mem_addr | output | 32 | Byte address (descriptor base + offset) |
| mem_data | output | 8 | Byte to write |

## Verification
The bench builds a four-entry ring with BUF_BYTES=24, MAX_FRAME=20 and a 3-bit overflow counter. The small buffer means a 23-byte frame exercises the length-violation flag with no truncation, and a 30-byte frame exercises both the flag and the clipping of writes and length, all within a few dozen cycles. The narrow counter lets a short run of dropped frames reach saturation. The ring is also shortened to two entries by setting the wrap bit early, which shows that the wrap flag, not the ring depth, decides where the index returns.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int BIT_EMPTY = 15;
  localparam int BIT_WRAP  = 13;
  localparam int BIT_LONG  = 5;
  localparam int BIT_RXERR = 0;
  localparam logic [31:0] KICK_VALUE = 32'h0100_0000;

  typedef logic [15:0] stat_t;
  typedef logic [15:0] len_t;

  // Status written back at frame close: ownership handed to host, error field rebuilt.
  function automatic stat_t close_status(stat_t s, logic rxerr, logic too_long);
    stat_t r;
    r = s;
    r[BIT_EMPTY] = 1'b0;
    r[5:0] = 6'b0;
    r[BIT_LONG] = too_long;
    r[BIT_RXERR] = rxerr;
    return r;
  endfunction

  function automatic len_t clip_len(len_t n, int unsigned cap);
    return (32'(n) > cap) ? cap[15:0] : n;
  endfunction

  function automatic len_t sat_inc(len_t n);
    return (n == 16'hFFFF) ? n : n + 16'd1;
  endfunction
endpackage

// File: rtl/rxr_desc_mem.sv
module rxr_desc_mem #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned IW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_en,
  input  logic [IW-1:0] hw_idx,
  input  logic          hw_field,
  input  logic [31:0]   hw_data,
  input  logic          ew_en,
  input  logic [IW-1:0] ew_idx,
  input  logic [15:0]   ew_stat,
  input  logic [15:0]   ew_len,
  input  logic [IW-1:0] er_idx,
  output logic [15:0]   er_stat,
  output logic [31:0]   er_base,
  input  logic [IW-1:0] hr_idx,
  input  logic          hr_field,
  output logic [31:0]   hr_word
);
  import rxr_pkg::*;

  logic [15:0] stat_arr [DEPTH];
  logic [15:0] len_arr  [DEPTH];
  logic [31:0] base_arr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [15:0] s_q, l_q;
    logic [31:0] b_q;
    wire eng_hit  = ew_en && (ew_idx == IW'(g));
    wire host_w0  = hw_en && !hw_field && (hw_idx == IW'(g));
    wire host_w1  = hw_en &&  hw_field && (hw_idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_q <= '0;
        l_q <= '0;
        b_q <= '0;
      end else begin
        if (eng_hit) begin
          s_q <= ew_stat;
          l_q <= ew_len;
        end else if (host_w0) begin
          {s_q, l_q} <= hw_data;
        end
        if (host_w1) b_q <= hw_data;
      end
    end
    assign stat_arr[g] = s_q;
    assign len_arr[g]  = l_q;
    assign base_arr[g] = b_q;
  end

  assign er_stat = stat_arr[er_idx];
  assign er_base = base_arr[er_idx];
  assign hr_word = hr_field ? base_arr[hr_idx] : {stat_arr[hr_idx], len_arr[hr_idx]};

  // Checker state: the descriptor written back by the engine must be host-owned afterwards.
  logic          chk_en_q;
  logic [IW-1:0] chk_idx_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_en_q  <= 1'b0;
      chk_idx_q <= '0;
    end else begin
      chk_en_q  <= ew_en;
      chk_idx_q <= ew_idx;
    end
  end

  p_handback_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en_q |-> !stat_arr[chk_idx_q][BIT_EMPTY]);
endmodule

// File: rtl/rxr_frame_ctl.sv
module rxr_frame_ctl #(
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned IW        = 2,
  parameter int unsigned BUF_BYTES = 1520,
  parameter int unsigned MAX_FRAME = 1518
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic          rx_err,
  input  logic          arm_pulse,
  input  logic [15:0]   cur_stat,
  input  logic [31:0]   cur_base,
  output logic [IW-1:0] cur_idx,
  output logic          ew_en,
  output logic [15:0]   ew_stat,
  output logic [15:0]   ew_len,
  output logic          ev_drop,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [7:0]    mem_data
);
  import rxr_pkg::*;

  function automatic logic [IW-1:0] step_idx(logic [IW-1:0] i, logic wrap);
    return (wrap || i == IW'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  logic        armed, in_frame, keep;
  logic [15:0] cnt;
  logic [31:0] base_q;

  // Named events for the assertions.
  logic        ev_first, ev_start_ok, ev_byte, ev_close, room;
  logic [15:0] off, cnt_next;
  logic [31:0] base_next;

  assign ev_first    = rx_valid && !in_frame;
  assign ev_start_ok = ev_first && armed && cur_stat[BIT_EMPTY];
  assign ev_drop     = ev_first && !ev_start_ok;
  assign ev_byte     = rx_valid && (in_frame ? keep : ev_start_ok);
  assign ev_close    = ev_byte && rx_last;
  assign off         = ev_first ? 16'd0 : cnt;
  assign room        = 32'(off) < BUF_BYTES;
  assign cnt_next    = sat_inc(off);
  assign base_next   = ev_first ? cur_base : base_q;

  assign ew_en   = ev_close;
  assign ew_len  = clip_len(cnt_next, BUF_BYTES);
  assign ew_stat = close_status(cur_stat, rx_err, 32'(cnt_next) > MAX_FRAME);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      in_frame <= 1'b0;
      keep     <= 1'b0;
      cnt      <= '0;
      base_q   <= '0;
      cur_idx  <= '0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
    end else begin
      mem_we <= ev_byte && room;
      if (ev_byte && room) begin
        mem_addr <= base_next + 32'(off);
        mem_data <= rx_data;
      end
      if (rx_valid) begin
        in_frame <= !rx_last;
        cnt      <= cnt_next;
        if (ev_first) begin
          keep   <= ev_start_ok;
          base_q <= cur_base;
        end
      end
      if (ev_close) cur_idx <= step_idx(cur_idx, cur_stat[BIT_WRAP]);
      if (arm_pulse) armed <= 1'b1;
      else if (ev_first && armed && !cur_stat[BIT_EMPTY]) armed <= 1'b0;
    end
  end

  p_arm_on_doorbell_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arm_pulse |=> armed);
  p_wrap_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_close && cur_stat[BIT_WRAP]) |=> (cur_idx == '0));
  p_drop_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> !mem_we);
  p_len_clip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ew_en |-> (32'(ew_len) <= BUF_BYTES));
endmodule

// File: rtl/rxr_host_port.sv
module rxr_host_port #(
  parameter int unsigned IW    = 2,
  parameter int unsigned OVF_W = 16,
  parameter int unsigned HA_W  = IW + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_we,
  input  logic            host_re,
  input  logic [HA_W-1:0] host_addr,
  input  logic [31:0]     host_wdata,
  output logic [31:0]     host_rdata,
  input  logic            ev_drop,
  input  logic [31:0]     hr_word,
  output logic            arm_pulse,
  output logic            hw_en,
  output logic [IW-1:0]   desc_idx,
  output logic            desc_field
);
  import rxr_pkg::*;

  logic             ctl_sel;
  logic [OVF_W-1:0] ovf;

  assign ctl_sel    = host_addr[HA_W-1];
  assign desc_idx   = host_addr[HA_W-2:1];
  assign desc_field = host_addr[0];
  assign hw_en      = host_we && !ctl_sel;
  assign arm_pulse  = host_we && ctl_sel && !host_addr[0] && (host_wdata == KICK_VALUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf        <= '0;
      host_rdata <= '0;
    end else begin
      if (ev_drop && ovf != '1) ovf <= ovf + 1'b1;
      if (host_re) host_rdata <= ctl_sel ? (host_addr[0] ? 32'(ovf) : 32'd0) : hr_word;
    end
  end

  p_drop_counts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_drop && ovf != '1) |=> (ovf == $past(ovf) + 1'b1));
  p_ovf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_drop |=> $stable(ovf));
endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine #(
  parameter int unsigned RING_DEPTH = 4,
  parameter int unsigned BUF_BYTES  = 1520,
  parameter int unsigned MAX_FRAME  = 1518,
  parameter int unsigned OVF_W      = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          host_we,
  input  logic                          host_re,
  input  logic [$clog2(RING_DEPTH)+1:0] host_addr,
  input  logic [31:0]                   host_wdata,
  output logic [31:0]                   host_rdata,
  input  logic                          rx_valid,
  input  logic [7:0]                    rx_data,
  input  logic                          rx_last,
  input  logic                          rx_err,
  output logic                          mem_we,
  output logic [31:0]                   mem_addr,
  output logic [7:0]                    mem_data
);
  localparam int unsigned IW   = $clog2(RING_DEPTH);
  localparam int unsigned HA_W = IW + 2;

  logic          arm_pulse, hw_en, desc_field, ew_en, ev_drop;
  logic [IW-1:0] desc_idx, cur_idx;
  logic [31:0]   hr_word, cur_base;
  logic [15:0]   cur_stat, ew_stat, ew_len;

  rxr_host_port #(.IW(IW), .OVF_W(OVF_W), .HA_W(HA_W)) u_host (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ev_drop(ev_drop), .hr_word(hr_word), .arm_pulse(arm_pulse),
    .hw_en(hw_en), .desc_idx(desc_idx), .desc_field(desc_field)
  );

  rxr_desc_mem #(.DEPTH(RING_DEPTH), .IW(IW)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .hw_en(hw_en), .hw_idx(desc_idx), .hw_field(desc_field), .hw_data(host_wdata),
    .ew_en(ew_en), .ew_idx(cur_idx), .ew_stat(ew_stat), .ew_len(ew_len),
    .er_idx(cur_idx), .er_stat(cur_stat), .er_base(cur_base),
    .hr_idx(desc_idx), .hr_field(desc_field), .hr_word(hr_word)
  );

  rxr_frame_ctl #(.DEPTH(RING_DEPTH), .IW(IW), .BUF_BYTES(BUF_BYTES), .MAX_FRAME(MAX_FRAME)) u_ctl (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_err(rx_err), .arm_pulse(arm_pulse),
    .cur_stat(cur_stat), .cur_base(cur_base), .cur_idx(cur_idx),
    .ew_en(ew_en), .ew_stat(ew_stat), .ew_len(ew_len), .ev_drop(ev_drop),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
  );
endmodule

// File: tb/sim_rx_ring_engine.sv
`timescale 1ns/1ps
module sim_rx_ring_engine;
  localparam int DEPTH = 4;
  localparam int BUFB  = 24;
  localparam int MAXF  = 20;
  localparam int OVFW  = 3;
  localparam logic [3:0] A_KICK = 4'b1000;
  localparam logic [3:0] A_OVF  = 4'b1001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_we = 0, host_re = 0, rx_valid = 0, rx_last = 0, rx_err = 0;
  logic [3:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata, mem_addr;
  logic [7:0] rx_data = '0, mem_data;
  logic mem_we;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [39:0] exp_q[$];

  always #2.5 clk = ~clk;

  rx_ring_engine #(.RING_DEPTH(DEPTH), .BUF_BYTES(BUFB), .MAX_FRAME(MAXF), .OVF_W(OVFW)) u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_err(rx_err), .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data));

  task automatic check(string tag, logic [39:0] act, logic [39:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every byte write (R3, R9).
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) check("R3/R9 unexpected byte write", {mem_addr, mem_data}, 40'h0);
      else check("R3 byte write", {mem_addr, mem_data}, exp_q.pop_front());
    end
  end

  task automatic host_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic host_chk(logic [3:0] a, logic [31:0] exp, string tag);
    @(negedge clk); host_re = 1; host_addr = a;
    @(negedge clk); host_re = 0;
    check(tag, {8'h0, host_rdata}, {8'h0, exp});
  endtask

  // Driver: pushes the expected writes of an accepted frame into the scoreboard.
  task automatic send_frame(int n, int seed, bit err, bit acc, logic [31:0] base);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = 8'(seed + k); rx_last = (k == n - 1); rx_err = err && (k == n - 1);
      if (acc && k < BUFB) exp_q.push_back({base + 32'(k), 8'(seed + k)});
    end
    @(negedge clk); rx_valid = 0; rx_last = 0; rx_err = 0;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    host_chk(A_OVF, 32'd0, "R1 overflow after reset");
    host_chk(4'd0, 32'd0, "R1 desc0 word0 after reset");
    host_chk(4'd7, 32'd0, "R1 desc3 base after reset");
    // Ring setup: base 0x1000*(i+1); desc2 has spare bit 6, desc3 wraps.
    for (int i = 0; i < DEPTH; i++) begin
      host_wr(4'(2 * i + 1), 32'h1000 * (i + 1));
      host_wr(4'(2 * i), (i == 2) ? 32'h8040_0000 : (i == 3) ? 32'hA000_0000 : 32'h8000_0000);
    end
    host_chk(4'd7, 32'h4000, "R10 desc3 base readback");
    // R7 disarmed drop
    send_frame(5, 8'h10, 0, 0, 0);
    host_chk(A_OVF, 32'd1, "R7 drop while disarmed");
    // R2 wrong doorbell value ignored
    host_wr(A_KICK, 32'h0000_0001);
    send_frame(5, 8'h20, 0, 0, 0);
    host_chk(A_OVF, 32'd2, "R2 wrong doorbell ignored");
    host_chk(4'd0, 32'h8000_0000, "R2 desc0 untouched");
    host_wr(A_KICK, 32'h0100_0000);
    send_frame(10, 8'h30, 0, 1, 32'h1000);
    host_chk(4'd0, 32'h0000_000A, "R4 desc0 writeback");
    send_frame(1, 8'h40, 1, 1, 32'h2000);
    host_chk(4'd2, 32'h0001_0001, "R8 error flag, single byte");
    send_frame(23, 8'h50, 0, 1, 32'h3000);
    host_chk(4'd4, 32'h0060_0017, "R9 long flag, R4 spare bit kept");
    send_frame(30, 8'h70, 0, 1, 32'h4000);
    host_chk(4'd6, 32'h2020_0018, "R9 truncation, R4 wrap kept");
    // R6 index wrapped to desc0 (not empty): disarm and drop
    send_frame(5, 8'h90, 0, 0, 0);
    host_chk(A_OVF, 32'd3, "R6 drop on busy descriptor");
    host_chk(4'd0, 32'h0000_000A, "R6 desc0 unchanged");
    host_wr(4'd0, 32'h8000_0000);
    send_frame(4, 8'hA0, 0, 0, 0);
    host_chk(A_OVF, 32'd4, "R6 still disarmed after return");
    host_wr(A_KICK, 32'h0100_0000);
    send_frame(6, 8'hB0, 0, 1, 32'h1000);
    host_chk(4'd0, 32'h0000_0006, "R5 wrap back to desc0");
    // R5 short ring: wrap on desc1
    host_wr(4'd2, 32'hA000_0000);
    send_frame(4, 8'hC0, 0, 1, 32'h2000);
    host_chk(4'd2, 32'h2000_0004, "R5 desc1 with wrap");
    host_wr(4'd0, 32'h8000_0000);
    send_frame(3, 8'hD0, 0, 1, 32'h1000);
    host_chk(4'd0, 32'h0000_0003, "R5 early wrap returns to 0");
    // R7 saturation: desc1 is host-owned, so drops pile up
    for (int j = 0; j < 4; j++) send_frame(2, 8'hE0, 0, 0, 0);
    host_chk(A_OVF, 32'd7, "R7 counter saturates");
    host_chk(4'd2, 32'h2000_0004, "R6 desc1 untouched by drops");
    check("R3 scoreboard drained", 40'(exp_q.size()), 40'd0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule